// File: doc/BRIEF.md
# Flash window decoder

This block sits between a register bus and a NAND flash controller. The controller reaches the flash only through a two-register window: an address register and a data register. Software writes an address word whose mode field (bits 27:26) sets what later data-register accesses do.

In direct mode (3), the low two bits of the address word select the kind of flash cycle:

- 0: command cycle.
- 1: address cycle.
- 2: data cycle.

Each data-register write then becomes one byte-wide flash bus cycle on a simple request/done interface. A data-register read with selector 2 fetches one byte from the flash.

In page-DMA mode (2), the low address bits give the starting page. The next three data-register writes form a descriptor, in this order:

1. A control word: page count in the low bits, burst length in bytes in bits 23:16, completion interrupt request in bit 24.
2. Bits 31:0 of the memory address.
3. Bits 63:32 of the memory address.

After the third write, the block raises a one-cycle start pulse together with the collected request. A short configuration write in this mode selects the flash area that later transfers use.

A data-register access that needs the flash interface while an earlier flash cycle is still in flight is stalled with a wait signal. It is then carried out in order and is never dropped.

Top module: `flash_window_dec`

## Requirements
- R1: After reset, fc_req_o, dma_start_o and area_sel_o are 0, all dma_* outputs are 0 and the address register reads 0.
- R2: Offset 0x00 is the address register and reads back the last 32-bit word written to it. Offset 0x10 is the data register. Writes to any other offset change nothing, and reads there return 0.
- R3: In mode 3 (address bits 27:26 = 3), a data-register write with selector (bits 1:0) 0, 1 or 2 raises fc_req_o in the cycle after acceptance. fc_kind_o is then 0 (command), 1 (address) or 2 (data write), and fc_wdata_o carries the low byte of the written word. Kind and byte hold until the cycle that has fc_done_i high, and fc_req_o is low in the next cycle.
- R4: In mode 3 with selector 2, a data-register read issues one flash cycle of kind 3 (data read). It holds bus_wait_o high until that cycle is done, then returns fc_rdata_i in bits 7:0 with 0 in bits 31:8.
- R5: A data-register access that needs a flash cycle while one is still in flight sees bus_wait_o high. It is not dropped: its cycle is issued after the earlier one completes. bus_wait_o is never high without bus_req_i.
- R6: In mode 2, the third descriptor write raises dma_start_o for exactly one cycle, in the cycle after acceptance. With it the block presents:
  - dma_page_o from the address word's low bits;
  - dma_count_o from control bits 7:0;
  - dma_burst_o from control bits 23:16;
  - dma_irq_o from control bit 24;
  - dma_addr_o = {third word, second word}.
- R7: Any write to the address register restarts the descriptor sequence, so earlier partial descriptor writes are discarded.
- R8: In mode 2, a data write made at the start of a descriptor whose bits 31:8 are all zero is an area-select command. Its low byte (0x42 selects the default main area) appears on area_sel_o, and the descriptor sequence does not advance.
- R9: Data-register writes in modes 0 and 1, or in mode 3 with selector 3, issue no flash cycle and no DMA start. Mode-3 data reads with selector 0 or 1 return 0 without wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request, held until not waited |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | OFS_W | Byte offset within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the accepting cycle |
| bus_wait_o | output | 1 | Stall the current access |
| fc_req_o | output | 1 | Flash cycle pending |
| fc_kind_o | output | 2 | 0 command, 1 address, 2 data write, 3 data read |
| fc_wdata_o | output | 8 | Byte for command, address or data write cycles |
| fc_done_i | input | 1 | Flash cycle finished this clock |
| fc_rdata_i | input | 8 | Byte returned by a data read cycle |
| dma_start_o | output | 1 | One-cycle DMA arm pulse |
| dma_page_o | output | PAGE_W | Starting page |
| dma_count_o | output | PCNT_W | Number of pages |
| dma_burst_o | output | 8 | Burst length in bytes |
| dma_irq_o | output | 1 | Interrupt on completion requested |
| dma_addr_o | output | 64 | Memory address |
| area_sel_o | output | 8 | Selected flash area code |

## Verification
The checks take for granted that a bus access keeps its request, direction, offset and data steady for as long as bus_wait_o is high. They also assume that fc_done_i comes only while fc_req_o is high, for a single cycle. Under these conditions a flash read in flight that the bus is still waiting on must keep the wait high. The bench drives every access through one task that holds all bus inputs until the wait drops. Its flash model answers each request with a single done pulse after a fixed delay, and never otherwise.

// File: rtl/fwin_pkg.sv
package fwin_pkg;
  typedef enum logic [1:0] {
    FC_CMD   = 2'd0,
    FC_ADDR  = 2'd1,
    FC_WDATA = 2'd2,
    FC_RDATA = 2'd3
  } fc_kind_e;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_RSVD   = 2'd1,
    MODE_DMA    = 2'd2,
    MODE_DIRECT = 2'd3
  } win_mode_e;

  localparam int MODE_LSB      = 26;
  localparam int CTL_BURST_LSB = 16;
  localparam int CTL_IRQ_BIT   = 24;
  localparam logic [7:0] OFS_ADDR_REG = 8'h00;
  localparam logic [7:0] OFS_DATA_REG = 8'h10;
endpackage

// File: rtl/fwin_decode.sv
module fwin_decode
  import fwin_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             wait_i,
  output logic [31:0]      addr_word_o,
  output logic             hit_addr_o,
  output logic             direct_wr_o,
  output logic             direct_rd_o,
  output logic             dma_wr_o,
  output logic             addr_wr_o
);
  localparam logic [OFS_W-1:0] OfsA = OFS_W'(OFS_ADDR_REG);
  localparam logic [OFS_W-1:0] OfsD = OFS_W'(OFS_DATA_REG);

  logic [31:0] addr_q;
  win_mode_e   mode;
  logic [1:0]  sel;
  logic        hit_d;
  logic        accept;

  assign mode   = win_mode_e'(addr_q[MODE_LSB+1:MODE_LSB]);
  assign sel    = addr_q[1:0];
  assign hit_d  = req_i && (addr_i == OfsD);
  assign accept = req_i && !wait_i;

  assign hit_addr_o  = req_i && (addr_i == OfsA);
  assign addr_wr_o   = accept && we_i && hit_addr_o;
  // selector 3 in direct mode is not a flash cycle
  assign direct_wr_o = hit_d && we_i && (mode == MODE_DIRECT) && (sel != 2'd3);
  assign direct_rd_o = hit_d && !we_i && (mode == MODE_DIRECT) && (sel == 2'd2);
  assign dma_wr_o    = accept && hit_d && we_i && (mode == MODE_DMA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_wr_o) addr_q <= wdata_i;
  end

  assign addr_word_o = addr_q;
endmodule

// File: rtl/fwin_fc_engine.sv
module fwin_fc_engine
  import fwin_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  fc_kind_e   kind_i,
  input  logic [7:0] wdata_i,
  input  logic       take_i,
  input  logic       done_i,
  input  logic [7:0] rdata_i,
  output logic       req_o,
  output fc_kind_e   kind_o,
  output logic [7:0] wdata_o,
  output logic       busy_o,
  output logic       rd_avail_o,
  output logic [7:0] rd_byte_o
);
  logic       req_q, avail_q;
  fc_kind_e   kind_q;
  logic [7:0] wdata_q, rbyte_q;
  logic       fin;

  assign fin = req_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      kind_q  <= FC_CMD;
      wdata_q <= '0;
    end else if (!req_q && start_i) begin
      req_q   <= 1'b1;
      kind_q  <= kind_i;
      wdata_q <= wdata_i;
    end else if (fin) begin
      req_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= 1'b0;
      rbyte_q <= '0;
    end else if (fin && kind_q == FC_RDATA) begin
      avail_q <= 1'b1;
      rbyte_q <= rdata_i;
    end else if (take_i) begin
      avail_q <= 1'b0;
    end
  end

  assign req_o      = req_q;
  assign kind_o     = kind_q;
  assign wdata_o    = wdata_q;
  assign busy_o     = req_q;
  assign rd_avail_o = avail_q;
  assign rd_byte_o  = rbyte_q;
endmodule

// File: rtl/fwin_dma_desc.sv
module fwin_dma_desc
  import fwin_pkg::*;
#(
  parameter int PAGE_W = 24,
  parameter int PCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              start_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [PCNT_W-1:0] count_o,
  output logic [7:0]        burst_o,
  output logic              irq_o,
  output logic [63:0]       addr_o,
  output logic [7:0]        area_o
);
  typedef enum logic [1:0] {ST_CTRL, ST_LO, ST_HI} step_e;

  step_e             step_q;
  logic [PCNT_W-1:0] cnt_q;
  logic [7:0]        burst_q;
  logic              irq_q;
  logic [31:0]       lo_q;
  logic              area_cmd, adv, last;

  assign area_cmd = wr_i && (step_q == ST_CTRL) && (wdata_i[31:8] == '0);
  assign adv      = wr_i && !area_cmd;
  assign last     = adv && (step_q == ST_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_CTRL;
      cnt_q   <= '0;
      burst_q <= '0;
      irq_q   <= 1'b0;
      lo_q    <= '0;
    end else if (clear_i) begin
      step_q  <= ST_CTRL;
    end else if (adv) begin
      unique case (step_q)
        ST_CTRL: begin
          cnt_q   <= wdata_i[PCNT_W-1:0];
          burst_q <= wdata_i[CTL_BURST_LSB+7:CTL_BURST_LSB];
          irq_q   <= wdata_i[CTL_IRQ_BIT];
          step_q  <= ST_LO;
        end
        ST_LO: begin
          lo_q   <= wdata_i;
          step_q <= ST_HI;
        end
        default: step_q <= ST_CTRL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      page_o  <= '0;
      count_o <= '0;
      burst_o <= '0;
      irq_o   <= 1'b0;
      addr_o  <= '0;
    end else begin
      start_o <= last;
      if (last) begin
        page_o  <= page_i;
        count_o <= cnt_q;
        burst_o <= burst_q;
        irq_o   <= irq_q;
        addr_o  <= {wdata_i, lo_q};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       area_o <= '0;
    else if (area_cmd) area_o <= wdata_i[7:0];
  end
endmodule

// File: rtl/flash_window_dec.sv
module flash_window_dec
  import fwin_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 24,
  parameter int PCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [OFS_W-1:0]  bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_wait_o,
  output logic              fc_req_o,
  output logic [1:0]        fc_kind_o,
  output logic [7:0]        fc_wdata_o,
  input  logic              fc_done_i,
  input  logic [7:0]        fc_rdata_i,
  output logic              dma_start_o,
  output logic [PAGE_W-1:0] dma_page_o,
  output logic [PCNT_W-1:0] dma_count_o,
  output logic [7:0]        dma_burst_o,
  output logic              dma_irq_o,
  output logic [63:0]       dma_addr_o,
  output logic [7:0]        area_sel_o
);
  logic [31:0] addr_word;
  logic        hit_addr, direct_wr, direct_rd, dma_wr, addr_wr;
  logic        busy, rd_avail, fc_start, take;
  logic [7:0]  rd_byte;
  fc_kind_e    start_kind, eng_kind;

  fwin_decode #(.OFS_W(OFS_W)) u_decode (
    .clk_i, .rst_ni,
    .req_i       (bus_req_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .wait_i      (bus_wait_o),
    .addr_word_o (addr_word),
    .hit_addr_o  (hit_addr),
    .direct_wr_o (direct_wr),
    .direct_rd_o (direct_rd),
    .dma_wr_o    (dma_wr),
    .addr_wr_o   (addr_wr)
  );

  assign bus_wait_o = (direct_wr && busy) || (direct_rd && !rd_avail);
  assign fc_start   = (direct_wr && !busy) || (direct_rd && !rd_avail && !busy);
  assign start_kind = direct_rd ? FC_RDATA : fc_kind_e'(addr_word[1:0]);
  assign take       = direct_rd && rd_avail;

  fwin_fc_engine u_engine (
    .clk_i, .rst_ni,
    .start_i    (fc_start),
    .kind_i     (start_kind),
    .wdata_i    (bus_wdata_i[7:0]),
    .take_i     (take),
    .done_i     (fc_done_i),
    .rdata_i    (fc_rdata_i),
    .req_o      (fc_req_o),
    .kind_o     (eng_kind),
    .wdata_o    (fc_wdata_o),
    .busy_o     (busy),
    .rd_avail_o (rd_avail),
    .rd_byte_o  (rd_byte)
  );
  assign fc_kind_o = eng_kind;

  fwin_dma_desc #(.PAGE_W(PAGE_W), .PCNT_W(PCNT_W)) u_desc (
    .clk_i, .rst_ni,
    .clear_i (addr_wr),
    .wr_i    (dma_wr),
    .wdata_i (bus_wdata_i),
    .page_i  (addr_word[PAGE_W-1:0]),
    .start_o (dma_start_o),
    .page_o  (dma_page_o),
    .count_o (dma_count_o),
    .burst_o (dma_burst_o),
    .irq_o   (dma_irq_o),
    .addr_o  (dma_addr_o),
    .area_o  (area_sel_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (hit_addr && !bus_we_i) bus_rdata_o = addr_word;
    else if (take)             bus_rdata_o = {24'h0, rd_byte};
  end
endmodule

// File: rtl/fwin_chk.sv
module fwin_chk #(
  parameter int OFS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic [OFS_W-1:0] bus_addr_i,
  input logic             bus_wait_o,
  input logic             fc_req_o,
  input logic [1:0]       fc_kind_o,
  input logic [7:0]       fc_wdata_o,
  input logic             fc_done_i,
  input logic             dma_start_o
);
  localparam logic [OFS_W-1:0] OfsD = OFS_W'(8'h10);

  assert_cycle_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_req_o && !fc_done_i |=> fc_req_o && $stable(fc_kind_o) && $stable(fc_wdata_o));

  assert_cycle_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_req_o && fc_done_i |=> !fc_req_o);

  assert_read_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_req_o && fc_kind_o == 2'd3 && bus_req_i && !bus_we_i && bus_addr_i == OfsD
    |-> bus_wait_o);

  assert_wait_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wait_o |-> bus_req_i);

  assert_start_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start_o |=> !dma_start_o);

  assert_start_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_start_o) |-> $past(bus_req_i && bus_we_i && bus_addr_i == OfsD));
endmodule

bind flash_window_dec fwin_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wait_o,
  .fc_req_o, .fc_kind_o, .fc_wdata_o, .fc_done_i, .dma_start_o
);

// File: tb/flash_window_dec_tb.sv
module flash_window_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FL_LAT     = 3;

  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        bus_wait;
  logic        fc_req, fc_done = 0;
  logic [1:0]  fc_kind;
  logic [7:0]  fc_wdata, fc_rdata = 8'h00;
  logic        dma_start, dma_irq;
  logic [23:0] dma_page;
  logic [7:0]  dma_count, dma_burst, area_sel;
  logic [63:0] dma_addr;

  int n_chk = 0, n_bad = 0, finished = 0;
  int log_n = 0, dma_n = 0;
  logic [1:0]  log_kind [64];
  logic [7:0]  log_data [64];
  logic [23:0] cap_page;
  logic [7:0]  cap_count, cap_burst;
  logic        cap_irq;
  logic [63:0] cap_addr;

  flash_window_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_wait_o(bus_wait),
    .fc_req_o(fc_req), .fc_kind_o(fc_kind), .fc_wdata_o(fc_wdata),
    .fc_done_i(fc_done), .fc_rdata_i(fc_rdata),
    .dma_start_o(dma_start), .dma_page_o(dma_page), .dma_count_o(dma_count),
    .dma_burst_o(dma_burst), .dma_irq_o(dma_irq), .dma_addr_o(dma_addr),
    .area_sel_o(area_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // flash model: one done pulse per request after FL_LAT waiting cycles
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (fc_done) fc_done = 0;
      else if (fc_req) begin
        if (lat == FL_LAT) begin
          fc_done = 1;
          lat = 0;
          if (log_n < 64) begin
            log_kind[log_n] = fc_kind;
            log_data[log_n] = fc_wdata;
          end
          log_n++;
        end else lat++;
      end
    end
  end

  // DMA monitor: counts high cycles of the start pulse
  initial forever begin
    @(negedge clk);
    if (dma_start) begin
      dma_n++;
      cap_page = dma_page; cap_count = dma_count; cap_burst = dma_burst;
      cap_irq = dma_irq; cap_addr = dma_addr;
    end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int waits);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d; waits = 0;
    #1;
    while (bus_wait) begin waits++; @(negedge clk); #1; end
    rd = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; int w;
    xfer(1'b1, a, d, rd, w);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] rd; int w;
    @(negedge clk);
    chk("R1 fc_req", fc_req, 0);
    chk("R1 dma_start", dma_start, 0);
    chk("R1 area_sel", area_sel, 0);
    chk("R1 dma_addr", dma_addr, 0);
    xfer(1'b0, 8'h00, 0, rd, w);
    chk("R1 addr reg", rd, 0);
  endtask

  task automatic t_regs();
    logic [31:0] rd; int w;
    wr(8'h00, 32'h0C00_0001);
    xfer(1'b0, 8'h00, 0, rd, w);
    chk("R2 addr readback", rd, 32'h0C00_0001);
    wr(8'h20, 32'hDEAD_BEEF);
    xfer(1'b0, 8'h20, 0, rd, w);
    chk("R2 other offset read", rd, 0);
    xfer(1'b0, 8'h00, 0, rd, w);
    chk("R2 addr untouched", rd, 32'h0C00_0001);
    settle();
    chk("R2 no flash cycle", log_n, 0);
  endtask

  task automatic t_direct();
    logic [31:0] rd; int w0, w1;
    int base;
    base = log_n;
    wr(8'h00, 32'h0C00_0000);
    wr(8'h10, 32'h1234_5670);
    wr(8'h00, 32'h0C00_0001);
    xfer(1'b1, 8'h10, 32'h0000_00AB, rd, w0);
    xfer(1'b1, 8'h10, 32'h0000_00CD, rd, w1);
    wr(8'h00, 32'h0C00_0002);
    wr(8'h10, 32'hFFFF_FF5A);
    settle();
    chk("R3 cycle count", log_n - base, 4);
    chk("R3 cmd kind", log_kind[base], 0);
    chk("R3 cmd byte", log_data[base], 8'h70);
    chk("R3 addr kind", log_kind[base+1], 1);
    chk("R3 addr byte", log_data[base+1], 8'hAB);
    chk("R5 stalled write waited", w1 > 0, 1);
    chk("R5 stalled write kept", log_data[base+2], 8'hCD);
    chk("R3 data kind", log_kind[base+3], 2);
    chk("R3 data byte", log_data[base+3], 8'h5A);
  endtask

  task automatic t_read();
    logic [31:0] rd; int w;
    int base;
    base = log_n;
    fc_rdata = 8'hC5;
    wr(8'h00, 32'h0C00_0002);
    xfer(1'b0, 8'h10, 0, rd, w);
    chk("R4 read byte", rd, 32'h0000_00C5);
    chk("R4 read waited", w > 0, 1);
    chk("R4 read kind", log_kind[base], 3);
    chk("R4 one cycle", log_n - base, 1);
  endtask

  task automatic t_ignored();
    logic [31:0] rd; int w;
    int base, dbase;
    base = log_n; dbase = dma_n;
    wr(8'h00, 32'h0400_0000);
    wr(8'h10, 32'h0000_0011);
    wr(8'h00, 32'h0000_0002);
    wr(8'h10, 32'h0000_0022);
    wr(8'h00, 32'h0C00_0003);
    wr(8'h10, 32'h0000_0033);
    wr(8'h00, 32'h0C00_0000);
    xfer(1'b0, 8'h10, 0, rd, w);
    chk("R9 sel0 read data", rd, 0);
    chk("R9 sel0 read no wait", w, 0);
    settle();
    chk("R9 no flash cycles", log_n - base, 0);
    chk("R9 no dma", dma_n - dbase, 0);
  endtask

  task automatic t_dma();
    int dbase;
    dbase = dma_n;
    wr(8'h00, 32'h0800_0123);
    wr(8'h10, 32'h0140_2005);
    wr(8'h10, 32'h89AB_CDEF);
    wr(8'h10, 32'h0000_0012);
    settle();
    chk("R6 single pulse", dma_n - dbase, 1);
    chk("R6 page", cap_page, 24'h000123);
    chk("R6 count", cap_count, 8'd5);
    chk("R6 burst", cap_burst, 8'd64);
    chk("R6 irq", cap_irq, 1);
    chk("R6 addr", cap_addr, 64'h0000_0012_89AB_CDEF);
  endtask

  task automatic t_restart();
    int dbase;
    dbase = dma_n;
    wr(8'h00, 32'h0800_0007);
    wr(8'h10, 32'h0140_2009);
    wr(8'h10, 32'h1111_1111);
    wr(8'h00, 32'h0800_0009);
    wr(8'h10, 32'h0020_0003);
    wr(8'h10, 32'h2222_2222);
    settle();
    chk("R7 no early start", dma_n - dbase, 0);
    wr(8'h10, 32'h0000_0001);
    settle();
    chk("R7 one start", dma_n - dbase, 1);
    chk("R7 page", cap_page, 24'h000009);
    chk("R7 count", cap_count, 8'd3);
    chk("R7 irq clear", cap_irq, 0);
    chk("R7 addr", cap_addr, 64'h0000_0001_2222_2222);
  endtask

  task automatic t_area();
    int dbase;
    dbase = dma_n;
    wr(8'h00, 32'h0800_0000);
    wr(8'h10, 32'h0000_0042);
    @(negedge clk);
    chk("R8 area sel", area_sel, 8'h42);
    wr(8'h10, 32'h0140_2002);
    wr(8'h10, 32'h0000_1000);
    settle();
    chk("R8 no advance", dma_n - dbase, 0);
    wr(8'h10, 32'h0000_0000);
    settle();
    chk("R8 start after three", dma_n - dbase, 1);
    chk("R8 count", cap_count, 8'd2);
  endtask

  task automatic summary();
    if (finished == 0) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_direct();
    t_read();
    t_ignored();
    t_dma();
    t_restart();
    t_area();
    summary();
  end
endmodule